// File: doc/BRIEF.md
# CEC Bit Receiver

This block listens to the single-wire consumer-electronics control bus and turns its pulse-width-coded traffic into bytes. Widths are measured with a counter that advances on a 1 MHz tick enable. The block qualifies the start bit and samples each data bit a fixed time after its falling edge. Bytes are packed most significant bit first. The block follows the end-of-message flag and answers the acknowledge slot on its own.

A frame is acknowledged when its destination matches a 16-bit logical-address mask. The line is pulled low to acknowledge a directed frame. For a broadcast frame the line is left released. When a bit period ends too early, the block holds the line low for an error pulse. A finished frame is presented as a byte vector, a length and a one-clock valid pulse. Those outputs hold until the next accepted start bit.

Top module: `cec_bit_receiver`

## Requirements
- R1: While reset is high, and on the clock after it, the line drive output is released, frame_valid is low and frame_len is zero.
- R2: A start-bit low phase shorter than 3500 µs is discarded and the block goes back to idle without starting a frame.
- R3: If the line is still high more than 4700 µs after the start-bit falling edge, or more than 2750 µs after a data-bit falling edge, the frame is abandoned and the block returns to idle.
- R4: Each data bit is sampled 850 µs after its falling edge. A sampled high is a 1 and a sampled low is a 0. Within each 10-bit group, bits 0..7 form a byte most significant bit first, and byte k of the frame appears on frame_bytes[8k+7:8k].
- R5: Bit 8 of each group is the end-of-message flag, where high means last. frame_len equals the number of bytes whose end-of-message bit was received.
- R6: A frame is delivered only after the acknowledge slot (bit 9) of a byte whose end-of-message flag is set, and only with the line high. Delivery happens no earlier than 1750 µs after that slot's falling edge. frame_valid is then high for exactly one clock.
- R7: The destination is bits 3:0 of byte 0. The acknowledge slot is driven low for 1500 µs when the mask bit for that destination is set. Destination 15 (broadcast) is never driven.
- R8: With the mask at zero, no acknowledge slot is ever driven.
- R9: When the line is low again less than 2050 µs after a data-bit falling edge, the block drives the line low for 3600 µs and then returns to idle.
- R10: frame_bytes and frame_len hold their values after delivery until the next start bit is accepted. A discarded start pulse does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock enable per microsecond |
| cec_in | input | 1 | Sampled bus level (1 = released/high) |
| la_mask | input | 16 | Logical addresses to acknowledge, bit n = address n |
| cec_drive_low | output | 1 | 1 pulls the bus low (open-drain enable) |
| frame_bytes | output | MAX_BYTES*8 | Received bytes, byte k at bits 8k+7:8k |
| frame_len | output | LEN_W | Number of bytes in the frame |
| frame_valid | output | 1 | One-clock pulse when a frame is complete |

## Verification
The bench places a malformed pulse directly in front of each good frame: a too-short start low, a start high that runs past its limit, and a data bit left high too long. A receiver that fails to drop these would take the next real falling edge as a data bit, and the good frame's bytes would come out shifted. A bit that is cut short must produce a 3600 µs error pulse, which a receiver comparing against the wrong threshold would skip. The acknowledge is checked for a directed match, for broadcast and for an empty mask, both while it is driven and after it is released. A polarity or lookup error therefore shows up as an acknowledge that is missing or unexpected. The timing of frame_valid against the last acknowledge falling edge catches a delivery made before the line can be read as high.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [3:0] {
    RX_IDLE,
    RX_START_LO,
    RX_START_HI,
    RX_BIT_SAMPLE,
    RX_BIT_REST,
    RX_BIT_HIGH,
    RX_ACK_DRIVE,
    RX_ACK_REST,
    RX_FINISH,
    RX_ERR_DRIVE
  } crx_state_e;
endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic line_o,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin_i};
  end

  assign line_o = sh[STAGES-1];
  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store #(
  parameter int MAX_BYTES = 16,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_byte,
  output logic [MAX_BYTES*8-1:0] bytes_o
);
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                                        bytes_o[8*k +: 8] <= '0;
      else if (wr_en && wr_idx == IDX_W'(k))          bytes_o[8*k +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/cec_bit_receiver.sv
module cec_bit_receiver
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES       = 16,
  parameter int LEN_W           = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int T_START_LOW_MIN = 3500,
  parameter int T_START_MAX     = 4700,
  parameter int T_SAMPLE        = 850,
  parameter int T_BACK_HIGH     = 1750,
  parameter int T_BIT_MIN       = 2050,
  parameter int T_BIT_MAX       = 2750,
  parameter int T_ACK_LOW       = 1500,
  parameter int T_LOW_DRIVE     = 3600
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_us,
  input  logic                   cec_in,
  input  logic [15:0]            la_mask,
  output logic                   cec_drive_low,
  output logic [MAX_BYTES*8-1:0] frame_bytes,
  output logic [LEN_W-1:0]       frame_len,
  output logic                   frame_valid
);
  localparam int CNT_W = $clog2(T_START_MAX + T_LOW_DRIVE) + 1;
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [CNT_W-1:0] C_START_MIN = CNT_W'(T_START_LOW_MIN);
  localparam logic [CNT_W-1:0] C_START_MAX = CNT_W'(T_START_MAX);
  localparam logic [CNT_W-1:0] C_SAMPLE    = CNT_W'(T_SAMPLE);
  localparam logic [CNT_W-1:0] C_HIGH      = CNT_W'(T_BACK_HIGH);
  localparam logic [CNT_W-1:0] C_BIT_MIN   = CNT_W'(T_BIT_MIN);
  localparam logic [CNT_W-1:0] C_BIT_MAX   = CNT_W'(T_BIT_MAX);
  localparam logic [CNT_W-1:0] C_ACK       = CNT_W'(T_ACK_LOW);
  localparam logic [CNT_W-1:0] C_LDRV      = CNT_W'(T_LOW_DRIVE);
  localparam logic [LEN_W-1:0] L_MAX       = LEN_W'(MAX_BYTES);

  crx_state_e        state, state_n;
  logic              line, rise, tclr;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        bitpos, dest;
  logic [LEN_W-1:0]  byte_cnt, len_q;
  logic [6:0]        shreg;
  logic              eom, valid_q, drv_q;
  logic              start_ok, smp, adv, deliver, ack_me, wr_en;

  cec_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(cec_in), .line_o(line), .rise_o(rise));

  cec_rx_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .clr(tclr), .cnt(cnt));

  cec_rx_store #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(byte_cnt[IDX_W-1:0]),
    .wr_byte({shreg, line}), .bytes_o(frame_bytes));

  // broadcast address 15 is never acknowledged by pulling low
  assign ack_me = (dest != 4'hF) && la_mask[dest];
  assign wr_en  = smp && (bitpos == 4'd7) && (byte_cnt < L_MAX);

  always_comb begin
    state_n  = state;
    tclr     = 1'b0;
    start_ok = 1'b0;
    smp      = 1'b0;
    adv      = 1'b0;
    deliver  = 1'b0;
    case (state)
      RX_IDLE: if (!line) begin state_n = RX_START_LO; tclr = 1'b1; end
      RX_START_LO: if (rise) state_n = (cnt < C_START_MIN) ? RX_IDLE : RX_START_HI;
      RX_START_HI: begin
        if (!line) begin
          state_n = RX_BIT_SAMPLE; tclr = 1'b1; start_ok = 1'b1;
        end else if (cnt > C_START_MAX) state_n = RX_IDLE;
      end
      RX_BIT_SAMPLE: if (cnt == C_SAMPLE) begin smp = 1'b1; state_n = RX_BIT_REST; end
      RX_BIT_REST:   if (cnt >= C_HIGH) state_n = RX_BIT_HIGH;
      RX_BIT_HIGH: begin
        if (!line) begin
          tclr = 1'b1;
          if (cnt < C_BIT_MIN) state_n = RX_ERR_DRIVE;
          else begin
            adv = 1'b1;
            if (bitpos == 4'd8) state_n = ack_me ? RX_ACK_DRIVE : RX_ACK_REST;
            else                state_n = RX_BIT_SAMPLE;
          end
        end else if (cnt > C_BIT_MAX) state_n = RX_IDLE;
      end
      RX_ACK_DRIVE: if (cnt >= C_ACK) state_n = RX_ACK_REST;
      RX_ACK_REST: begin
        if (cnt >= C_HIGH) begin
          if (line && eom) begin deliver = 1'b1; state_n = RX_FINISH; end
          else state_n = RX_BIT_HIGH;
        end
      end
      RX_FINISH:    if (cnt >= C_BIT_MIN) state_n = RX_IDLE;
      RX_ERR_DRIVE: if (cnt >= C_LDRV) state_n = RX_IDLE;
      default:      state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bitpos   <= '0;
      byte_cnt <= '0;
      len_q    <= '0;
      shreg    <= '0;
      dest     <= '0;
      eom      <= 1'b0;
      valid_q  <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      state   <= state_n;
      valid_q <= deliver;
      drv_q   <= (state_n == RX_ACK_DRIVE) || (state_n == RX_ERR_DRIVE);
      if (start_ok) begin
        bitpos   <= '0;
        byte_cnt <= '0;
        len_q    <= '0;
        eom      <= 1'b0;
      end
      if (smp) begin
        if (bitpos < 4'd8) shreg <= {shreg[5:0], line};
        if (bitpos == 4'd7 && byte_cnt == '0) dest <= {shreg[2:0], line};
        if (bitpos == 4'd8) begin
          eom   <= line;
          len_q <= (byte_cnt == '1) ? byte_cnt : byte_cnt + 1'b1;
        end
      end
      if (adv) begin
        if (bitpos == 4'd9) begin
          bitpos   <= '0;
          byte_cnt <= (byte_cnt == '1) ? byte_cnt : byte_cnt + 1'b1;
        end else bitpos <= bitpos + 1'b1;
      end
    end
  end

  assign cec_drive_low = drv_q;
  assign frame_len     = len_q;
  assign frame_valid   = valid_q;
endmodule

// File: rtl/cec_bit_receiver_chk.sv
module cec_bit_receiver_chk #(
  parameter int LEN_W       = 8,
  parameter int T_LOW_DRIVE = 3600
) (
  input logic             clk,
  input logic             rst,
  input logic             cec_drive_low,
  input logic             frame_valid,
  input logic [LEN_W-1:0] frame_len
);
  localparam int RW = $clog2(T_LOW_DRIVE + 8) + 1;
  localparam logic [RW-1:0] RUN_LIMIT = RW'(T_LOW_DRIVE + 4);
  logic [RW-1:0] drv_run;

  always_ff @(posedge clk) begin
    if (rst || !cec_drive_low) drv_run <= '0;
    else if (drv_run != '1)    drv_run <= drv_run + 1'b1;
  end

  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!cec_drive_low && !frame_valid && frame_len == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> frame_len != '0);

  a_r10_len_held: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> $stable(frame_len));

  a_r9_drive_bounded: assert property (@(posedge clk) disable iff (rst)
    drv_run <= RUN_LIMIT);
endmodule

bind cec_bit_receiver cec_bit_receiver_chk #(.LEN_W(LEN_W), .T_LOW_DRIVE(T_LOW_DRIVE)) u_chk (
  .clk(clk), .rst(rst), .cec_drive_low(cec_drive_low),
  .frame_valid(frame_valid), .frame_len(frame_len));

// File: tb/test_cec_bit_receiver.sv
module test_cec_bit_receiver;
  localparam int MAXB = 16;
  localparam int LW   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b1;
  logic tb_low = 1'b0;
  logic [15:0] la_mask = 16'h0000;
  logic cec_in, cec_drive_low, frame_valid;
  logic [MAXB*8-1:0] frame_bytes;
  logic [LW-1:0] frame_len;

  int checks = 0, errors = 0;
  int cyc = 0, vcount = 0, vcyc = 0, ack_fall_cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;  // 100 MHz, tick every clock: 1 clock stands for 1 us

  assign cec_in = ~(tb_low | cec_drive_low);

  cec_bit_receiver i_cec_bit_receiver (
    .clk(clk), .rst(rst), .tick_us(tick_us), .cec_in(cec_in), .la_mask(la_mask),
    .cec_drive_low(cec_drive_low), .frame_bytes(frame_bytes),
    .frame_len(frame_len), .frame_valid(frame_valid));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (frame_valid) begin vcount <= vcount + 1; vcyc <= cyc + 1; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    tb_low = 1'b1; wait_us(3700); tb_low = 1'b0; wait_us(800);
  endtask

  task automatic send_bit(input logic b);
    tb_low = 1'b1; wait_us(b ? 600 : 1500);
    tb_low = 1'b0; wait_us(b ? 1800 : 900);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last,
                           input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(last);
    ack_fall_cyc = cyc;
    tb_low = 1'b1; wait_us(600); tb_low = 1'b0; wait_us(400);
    chk({tag, " ack drive during slot"}, cec_drive_low, exp_ack);
    wait_us(600);
    chk({tag, " ack released"}, cec_drive_low, 1'b0);
    wait_us(800);
  endtask

  task automatic show_summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      show_summary();
      $finish;
    end
  end

  initial begin
    wait_us(3);
    chk("R1 drive in reset", cec_drive_low, 1'b0);
    chk("R1 valid in reset", frame_valid, 1'b0);
    chk("R1 len in reset", frame_len, 0);
    wait_us(7);
    rst = 1'b0;
    wait_us(100);

    // data-bit timeout, then a directed two-byte frame to address 4
    la_mask = 16'h0010;
    send_start(); send_bit(1'b0); send_bit(1'b1);
    wait_us(1000);
    vcount = 0;
    send_start();
    send_byte(8'h04, 1'b0, 1'b1, "R7 directed byte0");
    send_byte(8'hA5, 1'b1, 1'b1, "R7 directed byte1");
    wait_us(2100);
    chk("R6 one valid pulse", vcount, 1);
    chk("R6 delivery no earlier than 1750us",
        ((vcyc - ack_fall_cyc) >= 1750) && ((vcyc - ack_fall_cyc) <= 1765), 1'b1);
    chk("R5 two-byte length", frame_len, 2);
    chk("R4 byte0 after R3 data timeout", frame_bytes[7:0], 8'h04);
    chk("R4 byte1", frame_bytes[15:8], 8'hA5);

    // short start pulse, then a broadcast frame
    la_mask = 16'hFFFF;
    tb_low = 1'b1; wait_us(2000); tb_low = 1'b0; wait_us(1000);
    chk("R10 len held over short start", frame_len, 2);
    chk("R10 bytes held over short start", frame_bytes[15:0], 16'hA504);
    vcount = 0;
    send_start();
    send_byte(8'h3F, 1'b1, 1'b0, "R7 broadcast");
    wait_us(2100);
    chk("R6 broadcast delivered", vcount, 1);
    chk("R5 broadcast length", frame_len, 1);
    chk("R2 byte after discarded start", frame_bytes[7:0], 8'h3F);

    // start-high timeout, then a directed frame with an empty mask
    la_mask = 16'h0000;
    tb_low = 1'b1; wait_us(3700); tb_low = 1'b0; wait_us(5000);
    vcount = 0;
    send_start();
    send_byte(8'h24, 1'b1, 1'b0, "R8 empty mask");
    wait_us(2100);
    chk("R8 frame still delivered", vcount, 1);
    chk("R5 length", frame_len, 1);
    chk("R3 byte after start timeout", frame_bytes[7:0], 8'h24);

    // bit period cut short: error pulse
    send_start(); send_bit(1'b1);
    tb_low = 1'b1; wait_us(600); tb_low = 1'b0; wait_us(600);
    tb_low = 1'b1; wait_us(1000); tb_low = 1'b0; wait_us(1000);
    chk("R9 error drive active", cec_drive_low, 1'b1);
    wait_us(2300);
    chk("R9 error drive ended", cec_drive_low, 1'b0);
    wait_us(3000);
    chk("R9 no frame from aborted bits", vcount, 1);

    done = 1;
    show_summary();
    $finish;
  end
endmodule